// File: doc/BRIEF.md
# License-Gated Allowance Controller

This block is the control core of a hardware authorization gate. After reset it waits through a fixed settling delay. It then asks an internal nonce source for a fresh 256-bit challenge and publishes that challenge to the outside world. An external authority signs the challenge and returns a signature pair (r, s) with a one-cycle submit pulse. The controller latches the pair and hands it, together with the published challenge, to an external signature verifier. It talks to the verifier only through a start, busy, done and verdict handshake.

A good verdict adds a fixed credit to a 64-bit allowance counter, and a fresh challenge is then fetched, so one signature can never be spent twice. A bad verdict keeps the published challenge, so the sender can retry. The allowance falls by one on every clock whether or not work is present. While it is empty, the output of a stand-in signed 8-bit adder is forced to zero.

The nonce source is a free-running 256-bit counter that can be preloaded with a seed for test. A request copies the current count into a nonce register and raises a valid flag on the next cycle.

Top module: `license_gate`

## Requirements
- R1: While reset is high, and right after it, `state_debug` is 0, `allowance` is 0, `enabled` is 0, `accepted_count` is 0, `nonce_ready` is 0 and `ver_start` is 0.
- R2: The `state_debug` codes are: 0 settling delay, 1 request challenge, 2 wait challenge, 3 publish, 4 verify start, 5 verify wait, 6 update. The delay state counts cycles and leaves when its count reaches INIT_DELAY (100). The publish state is therefore first seen exactly INIT_DELAY+3 clock edges after reset is released.
- R3: The nonce counter starts at 0 after reset, increments every cycle, and is replaced by `seed_value` on a cycle where `seed_load` is high. A request copies the count. The copy is shown on `nonce_out` when the publish state is entered, and `nonce_ready` is high exactly in the publish state.
- R4: A `submit_pulse` seen in the publish state latches `sig_r` and `sig_s` onto `ver_r` and `ver_s` and moves the machine to verify start (code 4). There `ver_start` is high until `ver_busy` is low. Verify wait (code 5) holds until `ver_done`.
- R5: On a good verdict (`ver_ok` high with `ver_done`), the update state adds CREDIT (10^12) to the allowance. If the allowance was nonzero the net change that cycle is CREDIT-1. It also increments `accepted_count` and goes to request challenge (code 1), which yields a new challenge.
- R6: On a bad verdict the allowance only drains, `accepted_count` is unchanged, and the machine returns to publish with `nonce_out` unchanged. A signature for an earlier challenge is therefore refused.
- R7: The allowance drops by exactly one per clock while nonzero and holds at zero. `enabled` is high exactly when the allowance is nonzero.
- R8: `work_result` is the two's-complement wrapped sum `op_a + op_b` (127 + 1 gives -128). It is registered, so it appears one cycle after the inputs, and `result_valid` is `work_valid` delayed by one cycle.
- R9: When `enabled` is low in the input cycle, `work_result` is 0 in the following cycle.
- R10: A `submit_pulse` outside the publish state is ignored: `ver_r`, `ver_s` and the state do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| submit_pulse | input | 1 | One-cycle license submission strobe |
| sig_r | input | 256 | Signature component r |
| sig_s | input | 256 | Signature component s |
| work_valid | input | 1 | Workload operands valid |
| op_a | input | 8 | Signed operand A |
| op_b | input | 8 | Signed operand B |
| seed_value | input | 256 | Test seed for the nonce counter |
| seed_load | input | 1 | Load the test seed into the nonce counter |
| ver_busy | input | 1 | Verifier is working |
| ver_done | input | 1 | Verifier finished (one-cycle pulse) |
| ver_ok | input | 1 | Verifier verdict, sampled with ver_done |
| ver_start | output | 1 | Request the verifier to start |
| ver_z | output | 256 | Challenge given to the verifier |
| ver_r | output | 256 | Latched signature r given to the verifier |
| ver_s | output | 256 | Latched signature s given to the verifier |
| nonce_out | output | 256 | Published challenge |
| nonce_ready | output | 1 | Challenge is published and stable |
| work_result | output | 8 | Gated, registered workload sum |
| result_valid | output | 1 | work_result is valid |
| allowance | output | 64 | Current allowance |
| enabled | output | 1 | Allowance is nonzero |
| state_debug | output | 4 | Current state code |
| accepted_count | output | 16 | Number of licenses accepted |

## Verification
The credit from a good verdict and the per-clock drain can land on the same clock edge. The edge that leaves the update state both adds CREDIT and removes one unit whenever the allowance is already nonzero. The bench provokes this case by accepting a second license while credit from the first remains. It judges the result by reading the allowance in the update state and again after the next edge, expecting a rise of exactly CREDIT-1. An accepted license that arrives on an empty allowance is expected to give exactly CREDIT, with no decrement.

// File: rtl/gate_pkg.sv
`timescale 1ns/1ps
package gate_pkg;

    typedef enum logic [3:0] {
        ST_SETTLE = 4'd0,
        ST_ASK    = 4'd1,
        ST_AWAIT  = 4'd2,
        ST_PUB    = 4'd3,
        ST_VSTART = 4'd4,
        ST_VWAIT  = 4'd5,
        ST_UPDATE = 4'd6
    } gate_state_e;

    typedef struct packed {
        logic [7:0] sum;
        logic       vld;
    } work_out_t;

endpackage

// File: rtl/nonce_source.sv
`timescale 1ns/1ps
module nonce_source #(
    parameter int W = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] seed,
    input  logic         seed_load,
    input  logic         request,
    output logic [W-1:0] nonce,
    output logic         nonce_valid
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q     <= '0;
            nonce       <= '0;
            nonce_valid <= 1'b0;
        end else begin
            if (seed_load)
                count_q <= seed;
            else if (run)
                count_q <= count_q + 1'b1;
            if (request)
                nonce <= count_q;
            nonce_valid <= request;
        end
    end

    // R3
    req_then_valid_chk: assert property (@(posedge clk) disable iff (rst)
        request |=> nonce_valid);
endmodule

// File: rtl/allowance_counter.sv
`timescale 1ns/1ps
module allowance_counter #(
    parameter int           W      = 64,
    parameter logic [W-1:0] CREDIT = 64'd1_000_000_000_000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         credit_en,
    output logic [W-1:0] level,
    output logic         nonzero
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W:0]   sum_wide;
    logic [W-1:0] next_level;

    assign nonzero = (level != '0);

    always_comb begin
        sum_wide = {1'b0, level} + (credit_en ? {1'b0, CREDIT} : '0)
                 - {{W{1'b0}}, nonzero};
        next_level = sum_wide[W] ? ALL_ONES : sum_wide[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) level <= '0;
        else     level <= next_level;
    end

    // R7
    drain_one_chk: assert property (@(posedge clk) disable iff (rst)
        (!credit_en && nonzero) |=> (level == $past(level) - 1'b1));
    // R7
    floor_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!credit_en && !nonzero) |=> (level == '0));
    // R5
    credit_add_chk: assert property (@(posedge clk) disable iff (rst)
        (credit_en && (level <= ALL_ONES - CREDIT))
        |=> (level == $past(level) + CREDIT - {{(W-1){1'b0}}, ($past(level) != '0)}));
endmodule

// File: rtl/gated_adder.sv
`timescale 1ns/1ps
module gated_adder #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         allow,
    output logic [W-1:0] out,
    output logic         out_vld
);
    logic [W-1:0] raw_sum;

    assign raw_sum = a + b;

    always_ff @(posedge clk) begin
        if (rst) begin
            out     <= '0;
            out_vld <= 1'b0;
        end else begin
            out     <= raw_sum & {W{allow}};
            out_vld <= in_vld;
        end
    end

    // R9
    blocked_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !allow |=> (out == '0));
    // R8
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
endmodule

// File: rtl/license_gate.sv
`timescale 1ns/1ps
module license_gate
    import gate_pkg::*;
#(
    parameter int           NONCE_W    = 256,
    parameter int           SIG_W      = 256,
    parameter int           ALLOW_W    = 64,
    parameter int           COUNT_W    = 16,
    parameter int           OP_W       = 8,
    parameter int           INIT_DELAY = 100,
    parameter logic [63:0]  CREDIT     = 64'd1_000_000_000_000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               submit_pulse,
    input  logic [SIG_W-1:0]   sig_r,
    input  logic [SIG_W-1:0]   sig_s,
    input  logic               work_valid,
    input  logic [OP_W-1:0]    op_a,
    input  logic [OP_W-1:0]    op_b,
    input  logic [NONCE_W-1:0] seed_value,
    input  logic               seed_load,
    input  logic               ver_busy,
    input  logic               ver_done,
    input  logic               ver_ok,
    output logic               ver_start,
    output logic [NONCE_W-1:0] ver_z,
    output logic [SIG_W-1:0]   ver_r,
    output logic [SIG_W-1:0]   ver_s,
    output logic [NONCE_W-1:0] nonce_out,
    output logic               nonce_ready,
    output logic [OP_W-1:0]    work_result,
    output logic               result_valid,
    output logic [ALLOW_W-1:0] allowance,
    output logic               enabled,
    output logic [3:0]         state_debug,
    output logic [COUNT_W-1:0] accepted_count
);
    localparam int DLY_W = $clog2(INIT_DELAY + 1);

    gate_state_e        state;
    logic [DLY_W-1:0]   dly_q;
    logic [NONCE_W-1:0] nonce_q;
    logic [SIG_W-1:0]   r_q, s_q;
    logic               verdict_q;
    logic [COUNT_W-1:0] acc_q;
    logic               ask_nonce;
    logic [NONCE_W-1:0] src_nonce;
    logic               src_valid;
    logic               credit_en;
    work_out_t          work_q;

    assign ask_nonce = (state == ST_ASK);
    assign credit_en = (state == ST_UPDATE) && verdict_q;

    nonce_source #(.W(NONCE_W)) u_nonce (
        .clk(clk), .rst(rst), .run(1'b1),
        .seed(seed_value), .seed_load(seed_load),
        .request(ask_nonce), .nonce(src_nonce), .nonce_valid(src_valid)
    );

    allowance_counter #(.W(ALLOW_W), .CREDIT(ALLOW_W'(CREDIT))) u_allow (
        .clk(clk), .rst(rst), .credit_en(credit_en),
        .level(allowance), .nonzero(enabled)
    );

    gated_adder #(.W(OP_W)) u_work (
        .clk(clk), .rst(rst), .in_vld(work_valid),
        .a(op_a), .b(op_b), .allow(enabled),
        .out(work_q.sum), .out_vld(work_q.vld)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_SETTLE;
            dly_q     <= '0;
            nonce_q   <= '0;
            r_q       <= '0;
            s_q       <= '0;
            verdict_q <= 1'b0;
            acc_q     <= '0;
        end else begin
            unique case (state)
                ST_SETTLE: begin
                    if (dly_q >= DLY_W'(INIT_DELAY)) state <= ST_ASK;
                    else                             dly_q <= dly_q + 1'b1;
                end
                ST_ASK:   state <= ST_AWAIT;
                ST_AWAIT: begin
                    if (src_valid) begin
                        nonce_q <= src_nonce;
                        state   <= ST_PUB;
                    end
                end
                ST_PUB: begin
                    if (submit_pulse) begin
                        r_q   <= sig_r;
                        s_q   <= sig_s;
                        state <= ST_VSTART;
                    end
                end
                ST_VSTART: if (!ver_busy) state <= ST_VWAIT;
                ST_VWAIT: begin
                    if (ver_done) begin
                        verdict_q <= ver_ok;
                        state     <= ST_UPDATE;
                    end
                end
                ST_UPDATE: begin
                    if (verdict_q) begin
                        acc_q <= acc_q + 1'b1;
                        state <= ST_ASK;
                    end else begin
                        state <= ST_PUB;
                    end
                end
                default: state <= ST_SETTLE;
            endcase
        end
    end

    assign ver_start      = (state == ST_VSTART);
    assign ver_z          = nonce_q;
    assign ver_r          = r_q;
    assign ver_s          = s_q;
    assign nonce_out      = nonce_q;
    assign nonce_ready    = (state == ST_PUB);
    assign work_result    = work_q.sum;
    assign result_valid   = work_q.vld;
    assign state_debug    = state;
    assign accepted_count = acc_q;

    // R6
    retry_same_nonce_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_UPDATE && !verdict_q) |=> (state == ST_PUB && $stable(nonce_q)));
    // R10
    stray_submit_chk: assert property (@(posedge clk) disable iff (rst)
        (submit_pulse && state != ST_PUB) |=> ($stable(r_q) && $stable(s_q)));
    // R5
    accept_count_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_UPDATE && verdict_q) |=> (acc_q == $past(acc_q) + 1'b1 && state == ST_ASK));
    // R4
    wait_done_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_VWAIT && !ver_done) |=> (state == ST_VWAIT));
endmodule

// File: tb/license_gate_test.sv
`timescale 1ns/1ps
module license_gate_test;
    localparam logic [63:0]  CREDIT = 64'd1_000_000_000_000;
    localparam logic [255:0] KEY    = 256'h5A5A_1234_9876_F00D;
    localparam logic [255:0] SEED   = 256'hC0DE_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0040;
    // op_a, op_b, expected sum (R8 wrap cases)
    localparam logic [23:0] VEC [0:5] = '{
        24'h32_1E_50, 24'hF6_EC_E2, 24'h64_E2_46,
        24'h7F_01_80, 24'h80_FF_7F, 24'h01_FF_00
    };

    logic clk = 1'b0, rst = 1'b1;
    logic submit_pulse = 1'b0, work_valid = 1'b0, seed_load = 1'b0;
    logic [255:0] sig_r = '0, sig_s = '0, seed_value = '0;
    logic [7:0] op_a = '0, op_b = '0;
    logic vbusy, vdone, vok;
    int   vcnt;
    logic ver_start, nonce_ready, result_valid, enabled;
    logic [255:0] ver_z, ver_r, ver_s, nonce_out;
    logic [7:0] work_result;
    logic [63:0] allowance;
    logic [3:0] state_debug;
    logic [15:0] accepted_count;

    int checks = 0, errors = 0;
    logic [255:0] n0, old_r, old_s;
    logic [63:0] a0;

    always #2.5 clk = ~clk;

    license_gate uut (
        .clk(clk), .rst(rst), .submit_pulse(submit_pulse), .sig_r(sig_r), .sig_s(sig_s),
        .work_valid(work_valid), .op_a(op_a), .op_b(op_b),
        .seed_value(seed_value), .seed_load(seed_load),
        .ver_busy(vbusy), .ver_done(vdone), .ver_ok(vok), .ver_start(ver_start),
        .ver_z(ver_z), .ver_r(ver_r), .ver_s(ver_s), .nonce_out(nonce_out),
        .nonce_ready(nonce_ready), .work_result(work_result), .result_valid(result_valid),
        .allowance(allowance), .enabled(enabled), .state_debug(state_debug),
        .accepted_count(accepted_count)
    );

    // verifier model: good iff r == z+1 and s == z^KEY
    always @(posedge clk) begin
        vdone <= 1'b0;
        if (rst) begin
            vbusy <= 1'b0; vcnt <= 0; vok <= 1'b0;
        end else if (vbusy) begin
            if (vcnt == 1) begin
                vbusy <= 1'b0;
                vdone <= 1'b1;
                vok   <= (ver_r == ver_z + 1) && (ver_s == (ver_z ^ KEY));
            end
            vcnt <= vcnt - 1;
        end else if (ver_start) begin
            vbusy <= 1'b1; vcnt <= 6;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_state(input logic [3:0] s);
        for (int n = 0; n < 1000 && state_debug != s; n++) @(negedge clk);
    endtask

    // called at a negedge in publish; returns at the negedge in update
    task automatic send(input bit good, input bit poke);
        sig_r = good ? nonce_out + 1 : nonce_out + 2;
        sig_s = nonce_out ^ KEY;
        submit_pulse = 1'b1;
        @(negedge clk);
        submit_pulse = 1'b0;
        chk(state_debug == 4 && ver_start && ver_r == sig_r, "R4 verify start/latch",
            {state_debug, ver_start}, {4'd4, 1'b1});
        if (poke) begin
            @(negedge clk);
            sig_r = 256'hDEAD;
            submit_pulse = 1'b1;
            @(negedge clk);
            submit_pulse = 1'b0;
            chk(ver_r != 256'hDEAD && state_debug == 5, "R10 submit in verify wait",
                ver_r, 256'h0);
        end
        wait_state(4'd6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(state_debug == 0 && allowance == 0 && !enabled && accepted_count == 0
            && !nonce_ready && !ver_start, "R1 reset state", {state_debug, allowance}, 0);
        rst = 1'b0;
        sig_r = 256'h77; submit_pulse = 1'b1;   // R10 stray submit during delay
        cyc = 0;
        while (state_debug != 3 && cyc < 500) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) submit_pulse = 1'b0;
        end
        chk(cyc == 103, "R2 publish reached after INIT_DELAY+3 edges", cyc, 103);
        chk(ver_r == 0, "R10 submit outside publish ignored", ver_r, 0);
        chk(nonce_ready, "R3 nonce_ready in publish", nonce_ready, 1);
        chk(allowance == 0 && !enabled, "R7 allowance holds at zero", allowance, 0);

        // R9 blocked workload
        op_a = 8'd50; op_b = 8'd30; work_valid = 1'b1;
        @(negedge clk);
        work_valid = 1'b0;
        chk(work_result == 0 && result_valid, "R9 output gated when empty", work_result, 0);

        // R6 bad signature keeps challenge
        n0 = nonce_out;
        send(1'b0, 1'b0);
        @(negedge clk);
        chk(state_debug == 3 && nonce_out == n0, "R6 retry keeps nonce", nonce_out, n0);
        chk(allowance == 0 && accepted_count == 0, "R6 no credit on bad verdict",
            allowance, 0);

        // R5 good signature from empty; R3 seed load lands in next nonce
        send(1'b1, 1'b0);
        old_r = sig_r; old_s = sig_s;
        a0 = allowance;
        seed_value = SEED; seed_load = 1'b1;
        @(negedge clk);
        seed_load = 1'b0;
        chk(allowance == a0 + CREDIT, "R5 credit on empty allowance", allowance, a0 + CREDIT);
        chk(accepted_count == 1 && state_debug == 1, "R5 count and request",
            {accepted_count, state_debug}, {16'd1, 4'd1});
        wait_state(4'd3);
        chk(nonce_out == SEED, "R3 seeded nonce published", nonce_out, SEED);
        chk(nonce_out != n0, "R5 new nonce after acceptance", nonce_out, ~n0);

        // R7 drain by one per clock
        a0 = allowance;
        repeat (100) @(negedge clk);
        chk(allowance == a0 - 100 && enabled, "R7 drain 100 over 100 clocks",
            allowance, a0 - 100);

        // R8 workload table
        foreach (VEC[i]) begin
            op_a = VEC[i][23:16]; op_b = VEC[i][15:8]; work_valid = 1'b1;
            @(negedge clk);
            chk(work_result == VEC[i][7:0] && result_valid, "R8 wrapped sum",
                work_result, VEC[i][7:0]);
        end
        work_valid = 1'b0;
        @(negedge clk);
        chk(!result_valid, "R8 result_valid follows work_valid", result_valid, 0);

        // R6 replay of an old signature is refused
        sig_r = old_r; sig_s = old_s; submit_pulse = 1'b1;
        @(negedge clk);
        submit_pulse = 1'b0;
        wait_state(4'd6);
        @(negedge clk);
        chk(accepted_count == 1 && state_debug == 3 && nonce_out == SEED,
            "R6 replay refused", accepted_count, 1);

        // R5 credit and drain in the same edge; R10 stray submit in verify wait
        send(1'b1, 1'b1);
        a0 = allowance;
        @(negedge clk);
        chk(allowance == a0 + CREDIT - 1, "R5 credit minus drain", allowance, a0 + CREDIT - 1);
        chk(accepted_count == 2, "R5 second acceptance", accepted_count, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule